// File: doc/BRIEF.md
# Packed Q31-by-Q15 Saturating Multiply-Accumulate Unit

This execution unit serves a DSP datapath that works on packed 32-bit words. In every lane a signed 32-bit word from operand A is multiplied by one signed 16-bit half of the matching word of operand B. A control bit chooses which half of B is used. The most significant 32 bits of the 48-bit product become the addend. Two further control bits select how the addend is formed. Doubling treats the operands as Q31 and Q15 fractions and keeps the product aligned as a Q31 value. Rounding adds one half of the weight of the lowest kept bit before the discarded bits are dropped.

The addend is summed with the matching word of an accumulator operand, and the sum is clamped to the signed 32-bit range. A single overflow flag records any clamp and any forced fractional overflow in any lane. The flag stays set until the surrounding logic clears it. An operation without accumulation is obtained by supplying a zero accumulator. Each request is a single pulse on `in_valid`. The packed result and the updated flag appear one clock later.

Top module: `mac_q31x16_sat`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `result` is all zeros and `ovf_flag` is 0.
- R2: A request accepted on a rising edge with `in_valid` high produces `out_valid` high and the new `result` right after that edge. In a cycle without `in_valid`, `out_valid` is 0 and `result` keeps its previous value.
- R3: The 16-bit multiplier operand of lane i is taken from `op_b` bits [32i+15:32i] when `sel_top` is 0, and from bits [32i+31:32i+16] when `sel_top` is 1. It is read as signed two's complement.
- R4: When `dbl_mode` is 0 and `rnd_mode` is 0, the addend is the signed 48-bit product shifted right arithmetically by 16, which is product bits [47:16].
- R5: When `rnd_mode` is 1, 2^15 (plain) or 2^14 (doubling) is added to the product before the shift. The discarded bits therefore round half up, toward plus infinity.
- R6: When `dbl_mode` is 1, the addend is product bits [46:15], which is twice the product shifted right by 16.
- R7: When `dbl_mode` is 1, the A lane is 0x80000000 and the selected half is 0x8000, the addend is forced to 0x7FFFFFFF and the overflow flag is set. The flag is set whatever the accumulator holds.
- R8: A lane sum above 0x7FFFFFFF yields 0x7FFFFFFF, and a sum below -2^31 yields 0x80000000. Either clamp sets the overflow flag. Sums are formed at 33 bits, so no wrap is possible.
- R9: `ovf_flag` is sticky. It is set one clock after any lane of a valid request overflows. It is cleared by `ovf_clr` only in a cycle in which no new overflow arrives, because a same-cycle set wins over the clear.
- R10: Lanes are independent. Lane i uses and writes bits [32i+31:32i], and the lane count is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| sel_top | input | 1 | 1: upper halfword of each B lane, 0: lower halfword |
| dbl_mode | input | 1 | Q31 x Q15 doubling mode |
| rnd_mode | input | 1 | Round-half-up of the discarded product bits |
| ovf_clr | input | 1 | Synchronous clear of the sticky flag |
| op_a | input | LANES*32 | Packed 32-bit multiplicand words |
| op_b | input | LANES*32 | Packed words supplying the 16-bit multipliers |
| op_acc | input | LANES*32 | Packed accumulator words |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | LANES*32 | Packed saturated sums |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The in-RTL properties check the following on every cycle:
- the one-cycle valid timing and that `result` holds while idle;
- that the flag stays set and clears only as specified;
- that any clamp in a lane lands exactly on one of the two range limits;
- that the fractional corner pair always raises the flag.

The arithmetic itself can only be shown by the bench scenarios, which compare each lane against an integer reference model under all eight control combinations. These are the halfword choice, the exact rounding boundary, the doubled alignment, the corner pair with various accumulators, clamps on both sides, lanes that disagree and the set-wins-over-clear ordering.

// File: rtl/mac_q31x16_pkg.sv
package mac_q31x16_pkg;

  // Per-request arithmetic controls shared by every lane.
  typedef struct packed {
    logic use_top;  // pick upper halfword of the B lane
    logic dbl;      // fractional doubling
    logic rnd;      // round half up before truncation
  } mac_ctl_t;

endpackage

// File: rtl/mac_q31x16_addend.sv
// Per-lane multiplier and addend former: 32 x 16 signed product, optional
// doubling alignment, optional rounding bias and the fractional corner case.
module mac_q31x16_addend
  import mac_q31x16_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  mac_ctl_t          ctl,
  output logic [WORD_W-1:0] addend,
  output logic              corner
);

  localparam int PROD_W = WORD_W + HALF_W;
  localparam int EXT_W  = PROD_W + 1;
  localparam logic [EXT_W-1:0]  BIAS_PLAIN = EXT_W'(1) << (HALF_W - 1);
  localparam logic [EXT_W-1:0]  BIAS_DBL   = EXT_W'(1) << (HALF_W - 2);
  localparam logic [WORD_W-1:0] A_MIN      = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] H_MIN      = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] W_MAX      = {1'b0, {(WORD_W-1){1'b1}}};

  logic [HALF_W-1:0]        half;
  logic signed [PROD_W-1:0] prod;
  logic [EXT_W-1:0]         bias;
  logic [EXT_W-1:0]         biased;

  always_comb begin
    half   = ctl.use_top ? src_b[WORD_W-1 -: HALF_W] : src_b[HALF_W-1:0];
    prod   = $signed({{HALF_W{src_a[WORD_W-1]}}, src_a}) *
             $signed({{WORD_W{half[HALF_W-1]}}, half});
    bias   = !ctl.rnd ? '0 : (ctl.dbl ? BIAS_DBL : BIAS_PLAIN);
    biased = {prod[PROD_W-1], prod} + bias;
    corner = ctl.dbl && (src_a == A_MIN) && (half == H_MIN);
    if (corner) begin
      addend = W_MAX;
    end else if (ctl.dbl) begin
      addend = biased[HALF_W-1 +: WORD_W];
    end else begin
      addend = biased[HALF_W +: WORD_W];
    end
  end

endmodule

// File: rtl/mac_q31x16_satadd.sv
// Per-lane accumulate with a one-bit-wider sum and clamp to the word range.
module mac_q31x16_satadd #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] addend,
  output logic [WORD_W-1:0] sum_sat,
  output logic              clipped
);

  localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W:0] wide;

  always_comb begin
    wide    = {acc[WORD_W-1], acc} + {addend[WORD_W-1], addend};
    clipped = wide[WORD_W] ^ wide[WORD_W-1];
    if (clipped) begin
      sum_sat = wide[WORD_W] ? W_MIN : W_MAX;
    end else begin
      sum_sat = wide[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/mac_q31x16_sat.sv
// Packed saturating multiply-accumulate, one registered stage.
module mac_q31x16_sat
  import mac_q31x16_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    sel_top,
  input  logic                    dbl_mode,
  input  logic                    rnd_mode,
  input  logic                    ovf_clr,
  input  logic [LANES*WORD_W-1:0] op_a,
  input  logic [LANES*WORD_W-1:0] op_b,
  input  logic [LANES*WORD_W-1:0] op_acc,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] result,
  output logic                    ovf_flag
);

  localparam int VEC_W = LANES * WORD_W;
  localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] A_MIN = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] H_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  mac_ctl_t         ctl;
  logic [VEC_W-1:0] sum_vec;
  logic [LANES-1:0] lane_hit;

  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;
  logic             ovf_d, ovf_q;

  always_comb begin
    ctl.use_top = sel_top;
    ctl.dbl     = dbl_mode;
    ctl.rnd     = rnd_mode;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] lane_sum;
    logic              corner;
    logic              clipped;

    mac_q31x16_addend #(
      .WORD_W (WORD_W),
      .HALF_W (HALF_W)
    ) u_addend (
      .src_a  (op_a[i*WORD_W +: WORD_W]),
      .src_b  (op_b[i*WORD_W +: WORD_W]),
      .ctl    (ctl),
      .addend (addend),
      .corner (corner)
    );

    mac_q31x16_satadd #(
      .WORD_W (WORD_W)
    ) u_satadd (
      .acc     (op_acc[i*WORD_W +: WORD_W]),
      .addend  (addend),
      .sum_sat (lane_sum),
      .clipped (clipped)
    );

    assign sum_vec[i*WORD_W +: WORD_W] = lane_sum;
    assign lane_hit[i]                 = corner | clipped;

    // R8: a clamped lane lands exactly on a range limit
    p_clamp_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clipped |-> (lane_sum == W_MAX || lane_sum == W_MIN));

    // R7: the fractional corner pair always raises the flag
    p_corner_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dbl_mode && op_a[i*WORD_W +: WORD_W] == A_MIN &&
       (sel_top ? op_b[i*WORD_W+HALF_W +: HALF_W] : op_b[i*WORD_W +: HALF_W]) == H_MIN)
      |=> ovf_flag);
  end

  // Next-state logic
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? sum_vec : res_q;
    ovf_d = (in_valid & (|lane_hit)) | (ovf_q & ~ovf_clr);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign ovf_flag  = ovf_q;

  // R2: one-cycle latency
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2: idle cycles leave the result untouched
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R9: flag stays set unless cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R9: clear without a competing request empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !in_valid) |=> !ovf_flag);
  // R9: the flag only rises after a request
  p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(in_valid));

endmodule

// File: tb/mac_q31x16_sat_tb.sv
`timescale 1ns/1ps
module mac_q31x16_sat_tb;

  localparam int LN = 2;
  localparam int VW = LN * 32;
  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, sel_top, dbl_mode, rnd_mode, ovf_clr;
  logic [VW-1:0] op_a, op_b, op_acc;
  logic          out_valid, ovf_flag;
  logic [VW-1:0] result;

  int n_chk  = 0;
  int n_fail = 0;

  logic [VW-1:0] exp_res;
  logic          exp_vld;
  logic          exp_ovf;

  always #4 clk = ~clk;

  mac_q31x16_sat #(.LANES(LN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_top(sel_top),
    .dbl_mode(dbl_mode), .rnd_mode(rnd_mode), .ovf_clr(ovf_clr),
    .op_a(op_a), .op_b(op_b), .op_acc(op_acc),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural lane model on wide integers.
  function automatic void ref_lane(input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] acc, input bit top,
                                   input bit dbl, input bit rnd,
                                   output logic [31:0] r, output bit ov);
    longint av, hv, p, add, s;
    int sh;
    av = longint'($signed(a));
    hv = top ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    p  = av * hv;
    ov = 1'b0;
    if (dbl && a == 32'h8000_0000 && hv == -64'sd32768) begin
      add = QMAX;
      ov  = 1'b1;
    end else begin
      sh = dbl ? 15 : 16;
      if (rnd) p = p + (64'sd1 <<< (sh - 1));
      add = p >>> sh;
    end
    s = longint'($signed(acc)) + add;
    if (s > QMAX) begin s = QMAX; ov = 1'b1; end
    else if (s < QMIN) begin s = QMIN; ov = 1'b1; end
    r = s[31:0];
  endfunction

  // Drive one cycle (called at a falling edge), update the model, compare next falling edge.
  task automatic step(input string tag, input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] acc, input bit vld, input bit top,
                      input bit dbl, input bit rnd, input bit clr);
    logic [31:0] r;
    bit ov;
    bit any_ov;
    in_valid = vld; sel_top = top; dbl_mode = dbl; rnd_mode = rnd; ovf_clr = clr;
    op_a = a; op_b = b; op_acc = acc;
    any_ov = 1'b0;
    for (int i = 0; i < LN; i++) begin
      ref_lane(a[i*32 +: 32], b[i*32 +: 32], acc[i*32 +: 32], top, dbl, rnd, r, ov);
      if (vld) exp_res[i*32 +: 32] = r;
      any_ov = any_ov | ov;
    end
    exp_ovf = (vld & any_ov) | (exp_ovf & ~clr);
    exp_vld = vld;
    @(negedge clk);
    check({tag, " out_valid"}, VW'(out_valid), VW'(exp_vld));
    check({tag, " result"},    result,         exp_res);
    check({tag, " ovf_flag"},  VW'(ovf_flag),  VW'(exp_ovf));
  endtask

  function automatic logic [VW-1:0] pk(input logic [31:0] l1, input logic [31:0] l0);
    return {l1, l0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; sel_top = 0; dbl_mode = 0; rnd_mode = 0; ovf_clr = 0;
    op_a = '0; op_b = '0; op_acc = '0;
    exp_res = '0; exp_vld = 0; exp_ovf = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 out_valid", VW'(out_valid), '0);
    check("R1 result",    result,         '0);
    check("R1 ovf_flag",  VW'(ovf_flag),  '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 plain truncation, both signs
    step("R4", pk(32'hEDCB_A988, 32'h1234_5678), pk(32'h0000_0007, 32'h0000_0003), '0, 1, 0, 0, 0, 0);
    // R3 top halfword (negative) versus bottom
    step("R3", pk(32'h0100_0000, 32'h0001_0000), pk(32'hFFFE_0005, 32'h7FFF_0001), '0, 1, 1, 0, 0, 0);
    step("R3", pk(32'h0100_0000, 32'h0001_0000), pk(32'hFFFE_0005, 32'h7FFF_0001), '0, 1, 0, 0, 0, 0);
    // R5 exact half: product 0x8000 and -0x8000 in plain mode
    step("R5", pk(32'hFFFF_8000, 32'h0000_8000), pk(32'h0000_0001, 32'h0000_0001), '0, 1, 0, 0, 1, 0);
    step("R5", pk(32'hFFFF_8000, 32'h0000_8000), pk(32'h0000_0001, 32'h0000_0001), '0, 1, 0, 0, 0, 0);
    // R6 doubling with and without rounding (R5 half at bit 14)
    step("R6", pk(32'h4000_0000, 32'h0000_4000), pk(32'h0000_4000, 32'h0000_0001), pk(32'd10, 32'd0), 1, 0, 1, 0, 0);
    step("R5", pk(32'hFFFF_C000, 32'h0000_4000), pk(32'h0000_0001, 32'h0000_0001), '0, 1, 0, 1, 1, 0);
    // R2 idle cycles hold result
    step("R2", '1, '1, '1, 0, 1, 1, 1, 0);
    step("R2", '0, '0, '0, 0, 0, 0, 0, 0);
    // R7 corner pair, lane 0 only, bottom halfword, accumulator negative
    step("R7", pk(32'h1000_0000, 32'h8000_0000), pk(32'h0000_0002, 32'h0000_8000), pk(32'd0, 32'hFFFF_FFFB), 1, 0, 1, 0, 0);
    // R9 clear without request
    step("R9", '0, '0, '0, 0, 0, 0, 0, 1);
    // R7 corner in top half, lane 1, with rounding; R7 not in plain mode
    step("R7", pk(32'h8000_0000, 32'h0000_0000), pk(32'h8000_0000, 32'h0000_0000), '0, 1, 1, 1, 1, 0);
    step("R9", '0, '0, '0, 0, 0, 0, 0, 1);
    step("R7", pk(32'h8000_0000, 32'h8000_0000), pk(32'h8000_0000, 32'h0000_8000), '0, 1, 1, 0, 0, 0);
    // R8 positive and negative clamps, R10 lanes disagree
    step("R8", pk(32'h7FFF_FFFF, 32'h7FFF_FFFF), pk(32'h0000_7FFF, 32'h0000_7FFF), pk(32'h0000_0005, 32'h7FFF_FFF0), 1, 0, 0, 0, 0);
    step("R9", '0, '0, '0, 0, 0, 0, 0, 0);
    step("R9", '0, '0, '0, 0, 0, 0, 0, 1);
    step("R8", pk(32'h7FFF_FFFF, 32'h7FFF_FFFF), pk(32'h0000_8000, 32'h0000_8000), pk(32'h8000_0010, 32'h0000_0000), 1, 0, 0, 0, 0);
    // R9 set wins over a same-cycle clear
    step("R9", pk(32'h8000_0000, 32'h0), pk(32'h0000_8000, 32'h0), '0, 1, 0, 1, 0, 1);
    step("R9", pk(32'h0000_0100, 32'h0), pk(32'h0000_0100, 32'h0), '0, 1, 0, 0, 0, 1);
    // R10 exact boundary that does not clamp
    step("R10", pk(32'h0001_0000, 32'h0001_0000), pk(32'h0000_0001, 32'h0000_FFFF), pk(32'h7FFF_FFFE, 32'h8000_0001), 1, 0, 0, 0, 0);

    // Random sweep over all control combinations
    for (int k = 0; k < 400; k++) begin
      logic [VW-1:0] a, b, c;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) begin
        a[31:0] = 32'h8000_0000;
        b[15:0] = 16'h8000; b[31:16] = 16'h8000;
      end
      if ($urandom_range(0, 3) == 0) c[63:32] = {1'b0, {31{1'b1}}} - 32'($urandom_range(0, 3));
      step("R10 sweep", a, b, c, ($urandom_range(0, 5) != 0), 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom_range(0, 4) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule